// File: doc/BRIEF.md
# Opcode-Class Completion Acknowledger

This block answers a four-phase request/acknowledge handshake on behalf of a multi-cycle ALU. A controller raises `req` and presents a 4-bit ALU opcode. The block raises `ack` only after a wait long enough for that kind of operation to settle. It then holds `ack` until the controller withdraws `req`, and drops it one edge later. While `req` is high and `ack` is still low, the controller is stalled.

The waits come from one cumulative delay line built as a reference-clock counter. The shortest section covers logical operations. Each longer class adds only its own increment on top of the shorter sections. The increments, in clock ticks, are 90 (logical), 38 (add/subtract), 30 (multiply) and 163 (divide). That gives totals of 90, 128, 158 and 321 ticks. Each total already contains a 50% margin over the measured operation time.

The opcode is decoded into three select lines. These steer a chain of three 2:1 multiplexers that pick a tap on the line. The opcode is taken once, at the edge that first sees the request. Changes after that have no effect until the handshake ends.

Top module: `opclass_ack_delay`

## Requirements
- R1: While `req` is low and no handshake is in progress, `ack` stays low.
- R2: Opcodes 0x0 to 0x5 and 0xC to 0xF (logical, no-operation and unknown codes) raise `ack` exactly 90 rising edges after the edge that first samples `req` high.
- R3: Opcodes 0x6 (add), 0x7 (subtract), 0x8 (program-counter signed offset add) and 0x9 (program-counter unsigned increment) raise `ack` after 128 edges.
- R4: Opcode 0xA (multiply) raises `ack` after 158 edges.
- R5: Opcode 0xB (divide) raises `ack` after 321 edges.
- R6: Once `ack` is high, it stays high for as long as `req` stays high.
- R7: `ack` falls on the first rising edge that samples `req` low while `ack` is high.
- R8: The opcode is captured on the edge that first samples `req` high. A change of the opcode input during the handshake does not alter the latency.
- R9: A synchronous reset (`rst` high at a rising edge) forces `ack` low and abandons any count in progress. After reset, no `ack` appears without a new request.
- R10: After a completed handshake, a new request starts a fresh count with the latency of its own opcode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; one tick is one delay step |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request from the controller |
| opcode | input | 4 | ALU operation code, sampled with the request |
| ack | output | 1 | Completion acknowledge |

## Verification
A wrong tap selection or a bad counter load shows at the port as `ack` rising on the wrong edge. Each opcode's latency is therefore measured to the exact cycle, and a single-tick error is caught within one handshake. A stuck sequencing state shows either as `ack` refusing to fall one edge after `req` drops, or as a spurious `ack` after reset with no request pending. Both are observed within a few cycles of the stimulus.

// File: rtl/opclass_ack_delay.sv
module opclass_ack_delay #(
  parameter int OP_W       = 4,
  parameter int INC_LOGIC  = 90,
  parameter int INC_ADDSUB = 38,
  parameter int INC_MUL    = 30,
  parameter int INC_DIV    = 163,
  parameter logic [OP_W-1:0] OP_ADD_LO = 4'h6,
  parameter logic [OP_W-1:0] OP_ADD_HI = 4'h9,
  parameter logic [OP_W-1:0] OP_MUL    = 4'hA,
  parameter logic [OP_W-1:0] OP_DIV    = 4'hB
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req,
  input  logic [OP_W-1:0] opcode,
  output logic            ack
);

  localparam int TOTAL = INC_LOGIC + INC_ADDSUB + INC_MUL + INC_DIV;
  localparam int CW    = $clog2(TOTAL + 1);

  localparam logic [CW-1:0] TAP_LOGIC = CW'(INC_LOGIC);
  localparam logic [CW-1:0] TAP_ADD   = CW'(INC_LOGIC + INC_ADDSUB);
  localparam logic [CW-1:0] TAP_MUL   = CW'(INC_LOGIC + INC_ADDSUB + INC_MUL);
  localparam logic [CW-1:0] TAP_DIV   = CW'(TOTAL);

  typedef enum logic [1:0] {IDLE, BUSY, HOLD} state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic          is_add, is_mul, is_div;
  logic          sel0, sel1, sel2;
  logic [CW-1:0] mux0, mux1, tap;

  // select logic
  assign is_add = (opcode >= OP_ADD_LO) && (opcode <= OP_ADD_HI);
  assign is_mul = (opcode == OP_MUL);
  assign is_div = (opcode == OP_DIV);
  assign sel2   = is_div;
  assign sel1   = is_mul | sel2;
  assign sel0   = is_add | sel1;

  // cascaded taps through three 2:1 muxes
  assign mux0 = sel0 ? TAP_ADD : TAP_LOGIC;
  assign mux1 = sel1 ? TAP_MUL : mux0;
  assign tap  = sel2 ? TAP_DIV : mux1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= IDLE;
      cnt   <= '0;
      ack   <= 1'b0;
    end else begin
      case (state)
        IDLE: if (req) begin
          cnt   <= tap - 1'b1;
          state <= BUSY;
        end
        BUSY: if (cnt == '0) begin
          ack   <= 1'b1;
          state <= HOLD;
        end else begin
          cnt <= cnt - 1'b1;
        end
        HOLD: if (!req) begin
          ack   <= 1'b0;
          state <= IDLE;
        end
        default: state <= IDLE;
      endcase
    end
  end

endmodule

// File: rtl/opclass_ack_delay_chk.sv
module opclass_ack_delay_chk #(
  parameter int OP_W    = 4,
  parameter int LAT_MAX = 321
) (
  input logic            clk,
  input logic            rst,
  input logic            req,
  input logic [OP_W-1:0] opcode,
  input logic            ack
);

  int unsigned wait_cnt;

  always_ff @(posedge clk) begin
    if (rst || ack || !req) wait_cnt <= 0;
    else if (wait_cnt <= LAT_MAX + 1) wait_cnt <= wait_cnt + 1;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) (!req && !ack) |=> !ack); // R1
  AST_LAT_BOUND:  assert property (@(posedge clk) disable iff (rst) wait_cnt <= LAT_MAX + 1); // R5
  AST_ACK_HOLD:   assert property (@(posedge clk) disable iff (rst) (ack && req) |=> ack); // R6
  AST_ACK_DROP:   assert property (@(posedge clk) disable iff (rst) (ack && !req) |=> !ack); // R7
  AST_RESET_LOW:  assert property (@(posedge clk) rst |=> !ack); // R9
  AST_OP_KNOWN:   assert property (@(posedge clk) disable iff (rst) req |-> !$isunknown(opcode)); // R8

endmodule

bind opclass_ack_delay opclass_ack_delay_chk #(
  .OP_W(OP_W),
  .LAT_MAX(INC_LOGIC + INC_ADDSUB + INC_MUL + INC_DIV)
) u_chk (
  .clk(clk), .rst(rst), .req(req), .opcode(opcode), .ack(ack)
);

// File: tb/opclass_ack_delay_test.sv
`timescale 1ns/1ps
module opclass_ack_delay_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req = 1'b0;
  logic [3:0] opcode = 4'h0;
  logic       ack;
  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  opclass_ack_delay uut (.clk(clk), .rst(rst), .req(req), .opcode(opcode), .ack(ack));

  function automatic int exp_lat(input logic [3:0] op);
    int t = 90;
    if (op >= 4'h6 && op <= 4'hB) t += 38;
    if (op == 4'hA || op == 4'hB) t += 30;
    if (op == 4'hB) t += 163;
    return t;
  endfunction

  function automatic string lat_tag(input logic [3:0] op);
    if (op >= 4'h6 && op <= 4'h9) return "R3";
    if (op == 4'hA) return "R4";
    if (op == 4'hB) return "R5";
    return "R2";
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic handshake(input logic [3:0] op, input bit chg, input logic [3:0] op2);
    int n = 0;
    int exp = exp_lat(op);
    @(negedge clk);
    req = 1'b1;
    opcode = op;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (chg && n == 3) opcode = op2;
    end while (!ack && n < 1000);
    if (chg) check(n - 1 == exp, "R8", n - 1, exp);
    else     check(n - 1 == exp, lat_tag(op), n - 1, exp);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      check(ack == 1'b1, "R6", ack, 1);
    end
    req = 1'b0;
    @(negedge clk);
    check(ack == 1'b0, "R7", ack, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(ack == 1'b0, "R9", ack, 0);
    rst = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (i == 19) check(ack == 1'b0, "R1", ack, 0);
    end
    // R10: back-to-back sweep of every opcode
    for (int op = 0; op < 16; op++) handshake(4'(op), 1'b0, 4'h0);
    // R8: opcode changes mid-handshake
    handshake(4'h1, 1'b1, 4'hB);
    handshake(4'hB, 1'b1, 4'h0);
    handshake(4'h7, 1'b1, 4'hA);
    // R9: reset abandons a count in progress
    @(negedge clk);
    req = 1'b1;
    opcode = 4'hB;
    repeat (40) @(negedge clk);
    rst = 1'b1;
    req = 1'b0;
    @(negedge clk);
    check(ack == 1'b0, "R9", ack, 0);
    rst = 1'b0;
    begin
      bit seen = 0;
      for (int i = 0; i < 340; i++) begin
        @(negedge clk);
        if (ack) seen = 1;
      end
      check(!seen, "R9", seen, 0);
    end
    handshake(4'h9, 1'b0, 4'h0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule